// File: doc/BRIEF.md
# Time-Shared Output Compare Unit

This block watches a free-running timer that lives outside it. It raises events when that timer reaches values loaded by software. It has four compare channels, grouped in two pairs. Each channel holds a compare value. The block does not give each channel its own equality comparator. Instead, one comparator visits the channels in turn, one channel per clock cycle. The timer moves at most once per full round, so every channel still sees every timer value. When a compare succeeds, the channel latches an event flag, and that flag can raise an interrupt line.

Each channel also owns an output pin level, and each pair has a mode bit that decides how that level is used. In waveform mode, a compare event inverts the level, so the pin traces a square wave whose edges fall on the programmed timer values. In direct mode, events never touch the level, and the pin simply shows the bit that software last wrote. Every pin has an enable. The enable tells the surrounding pad logic whether the block drives the pin or leaves it to the general-purpose port.

Software reaches all state through a flat register port. Writes take effect on the clock edge, and reads are combinational.

Top module: `ocq_top`

## Requirements
- R1: After reset, every control field reads 0. This covers start, interrupt enable, event flag, pin level, output enable and mode. `pin_oe_o` and `irq_o` are 0. The compare registers hold no guaranteed value.
- R2: Addresses 0 to 3 hold the 16-bit compare values of channels 0 to 3. Address 4 holds the control word of pair 0 (channels 0 and 1), and address 5 holds the control word of pair 1 (channels 2 and 3). In a control word, bit pairs carry {second channel, first channel} at these positions: start [1:0], interrupt enable [5:4], event flag [7:6], pin level [9:8], output enable [11:10]. Bit 12 is the mode (0 = waveform, 1 = direct). All implemented fields read back as last written, except for flag and level updates made by hardware.
- R3: Channel k is compared on the clock edges n = k, k+4, k+8 and so on, where n counts edges since reset release from 0. An event occurs only when the channel's start bit is set and its compare value equals `timer_i`, and the equality did not already hold at that channel's previous visit. A timer value held for several rounds therefore gives one event.
- R4: An event sets the channel's flag, and the flag stays set. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R5: `irq_o[k]` is 1 exactly when the flag and the interrupt enable of channel k are both 1.
- R6: In waveform mode, an event inverts the channel's pin level on the following cycle.
- R7: In direct mode, events leave the pin level unchanged. The pin shows the level bit that software wrote.
- R8: Every write to a control word loads both pin levels of that pair, in either mode. Later events toggle from the loaded value. If a write and an event hit the same channel in the same cycle, the written value is kept.
- R9: `pin_o[k]` is the channel's pin level, and `pin_oe_o[k]` is its output enable bit.
- R10: Control bits 2, 3 and 13 to 15 read as 0, and writes to them are ignored. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_i | input | 16 | Free-running timer value |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 4 | Per-channel interrupt request |
| pin_o | output | 4 | Per-channel pin level |
| pin_oe_o | output | 4 | Per-channel pin drive enable |

## Verification
The properties assume that `timer_i` changes at most once every four clocks. Under that assumption a missed compare cannot happen, and an event marks a fresh equality, not a stale one. The bench's timer process never advances faster than that. Its step interval changes between four and a dozen clocks, so timer values that persist over several scan rounds are also exercised. Random register traffic is allowed to collide with events, so the write-versus-event priority rules get tested. A behavioural model compares the outputs and the read data on every clock.

// File: rtl/ocq_pkg.sv
package ocq_pkg;
    // Bit positions inside a pair control word
    localparam int unsigned CB_START = 0;
    localparam int unsigned CB_IE    = 4;
    localparam int unsigned CB_FLAG  = 6;
    localparam int unsigned CB_LVL   = 8;
    localparam int unsigned CB_OE    = 10;
    localparam int unsigned CB_MODE  = 12;
    localparam int unsigned CB_USED  = 13;

    typedef enum logic {
        MODE_WAVE   = 1'b0,
        MODE_DIRECT = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/ocq_scan.sv
module ocq_scan #(
    parameter int unsigned NCH = 4,
    parameter int unsigned TW  = 16,
    localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TW-1:0]           timer_i,
    input  logic [NCH-1:0][TW-1:0]  cmp_i,
    input  logic [NCH-1:0]          start_i,
    output logic [NCH-1:0]          match_o
);
    typedef struct packed {
        logic [SW-1:0]  slot;
        logic [NCH-1:0] eq;
    } scan_t;

    scan_t s_d, s_q;
    logic  hit;

    always_comb begin
        s_d     = s_q;
        match_o = '0;
        hit     = (cmp_i[s_q.slot] == timer_i);
        // event only on a fresh equality at this channel's visit
        match_o[s_q.slot] = hit & ~s_q.eq[s_q.slot] & start_i[s_q.slot];
        s_d.eq[s_q.slot]  = hit;
        if (s_q.slot == SW'(NCH - 1)) begin
            s_d.slot = '0;
        end else begin
            s_d.slot = s_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ocq_chan.sv
module ocq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic direct_i,
    input  logic wr_i,
    input  logic wflag_i,
    input  logic wlvl_i,
    output logic flag_o,
    output logic lvl_o
);
    typedef struct packed {
        logic flag;
        logic lvl;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        // hardware set beats software clear
        c_d.flag = match_i | (c_q.flag & ~(wr_i & ~wflag_i));
        if (wr_i) begin
            c_d.lvl = wlvl_i;
        end else if (match_i && !direct_i) begin
            c_d.lvl = ~c_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign flag_o = c_q.flag;
    assign lvl_o  = c_q.lvl;
endmodule

// File: rtl/ocq_top.sv
module ocq_top
    import ocq_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned TW  = 16,
    parameter int unsigned AW  = $clog2(NCH + NCH / 2 + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  timer_i,
    input  logic           we_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [TW-1:0]  wdata_i,
    output logic [TW-1:0]  rdata_o,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] pin_oe_o
);
    localparam int unsigned NP = NCH / 2;

    typedef struct packed {
        logic [NCH-1:0][TW-1:0] cmp;
        logic [NCH-1:0]         start;
        logic [NCH-1:0]         ie;
        logic [NCH-1:0]         oe;
        logic [NP-1:0]          mode;
    } regs_t;

    regs_t r_d, r_q;

    logic [NP-1:0]  pair_wr;
    logic [NCH-1:0] match_w;
    logic [NCH-1:0] flag_w;
    logic [NCH-1:0] lvl_w;
    logic [NCH-1:0] start_w;
    logic [NP-1:0]  mode_w;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            pair_wr[p] = we_i && (addr_i == AW'(NCH + p));
        end
    end

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr_i == AW'(i)) begin
                    r_d.cmp[i] = wdata_i;
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (pair_wr[p]) begin
                r_d.start[2*p +: 2] = wdata_i[CB_START +: 2];
                r_d.ie[2*p +: 2]    = wdata_i[CB_IE +: 2];
                r_d.oe[2*p +: 2]    = wdata_i[CB_OE +: 2];
                r_d.mode[p]         = wdata_i[CB_MODE];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_w = r_q.start;
    assign mode_w  = r_q.mode;

    ocq_scan #(.NCH(NCH), .TW(TW)) scan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .timer_i (timer_i),
        .cmp_i   (r_q.cmp),
        .start_i (r_q.start),
        .match_o (match_w)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        ocq_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .match_i  (match_w[k]),
            .direct_i (r_q.mode[k/2] == MODE_DIRECT),
            .wr_i     (pair_wr[k/2]),
            .wflag_i  (wdata_i[CB_FLAG + k%2]),
            .wlvl_i   (wdata_i[CB_LVL + k%2]),
            .flag_o   (flag_w[k]),
            .lvl_o    (lvl_w[k])
        );
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr_i == AW'(i)) begin
                rdata_o = r_q.cmp[i];
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (addr_i == AW'(NCH + p)) begin
                rdata_o[CB_START +: 2] = r_q.start[2*p +: 2];
                rdata_o[CB_IE +: 2]    = r_q.ie[2*p +: 2];
                rdata_o[CB_FLAG +: 2]  = flag_w[2*p +: 2];
                rdata_o[CB_LVL +: 2]   = lvl_w[2*p +: 2];
                rdata_o[CB_OE +: 2]    = r_q.oe[2*p +: 2];
                rdata_o[CB_MODE]       = r_q.mode[p];
            end
        end
    end

    assign irq_o    = flag_w & r_q.ie;
    assign pin_o    = lvl_w;
    assign pin_oe_o = r_q.oe;
endmodule

// File: rtl/ocq_chk.sv
module ocq_chk #(
    parameter int unsigned NCH = 4,
    localparam int unsigned NP = NCH / 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] match_v,
    input logic [NCH-1:0] start_v,
    input logic [NCH-1:0] flag_v,
    input logic [NP-1:0]  mode_v,
    input logic [NP-1:0]  pair_wr,
    input logic [NCH-1:0] pin_o,
    input logic [NCH-1:0] pin_oe_o
);
    a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_v));

    a_r9_oe_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pair_wr) |=> $stable(pin_oe_o));

    for (genvar k = 0; k < NCH; k++) begin : g_k
        a_r3_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
            match_v[k] |-> start_v[k]);

        a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            match_v[k] |=> flag_v[k]);

        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            flag_v[k] && !pair_wr[k/2] |=> flag_v[k]);

        a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            match_v[k] && !mode_v[k/2] && !pair_wr[k/2]
            |=> pin_o[k] != $past(pin_o[k]));

        a_r7_direct_steady: assert property (@(posedge clk) disable iff (!rst_n)
            mode_v[k/2] && !pair_wr[k/2] |=> $stable(pin_o[k]));
    end
endmodule

bind ocq_top ocq_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_v  (match_w),
    .start_v  (start_w),
    .flag_v   (flag_w),
    .mode_v   (mode_w),
    .pair_wr  (pair_wr),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
);

// File: tb/ocq_top_tb.sv
`timescale 1ns/1ps
module ocq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  irq, pin, pin_oe;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int tdiv = 4;
    int tcnt = 0;

    always #4 clk = ~clk;

    ocq_top dut_i (
        .clk(clk), .rst_n(rst_n), .timer_i(timer), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pin_o(pin), .pin_oe_o(pin_oe)
    );

    // timer source: one step every tdiv clocks (tdiv >= 4)
    always @(negedge clk) begin
        if (rst_n) begin
            tcnt++;
            if (tcnt >= tdiv) begin
                tcnt = 0;
                timer = timer + 16'd1;
            end
        end
    end

    // ---------------- behavioural reference ----------------
    bit [15:0] mcmp [4];
    bit mstart[4], mie[4], moe[4], mflag[4], mlvl[4], mseen[4];
    bit mmode[2];
    int cyc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                mcmp[i] = 0; mstart[i] = 0; mie[i] = 0; moe[i] = 0;
                mflag[i] = 0; mlvl[i] = 0; mseen[i] = 0;
            end
            mmode[0] = 0; mmode[1] = 0;
            cyc = 0;
        end else begin
            int ch;
            bit eqn, ev;
            ch  = cyc % 4;
            eqn = (mcmp[ch] == timer);
            ev  = eqn && !mseen[ch] && mstart[ch];
            mseen[ch] = eqn;
            for (int i = 0; i < 4; i++) begin
                bit wp, e;
                wp = we && (addr == 3'(4 + i / 2));
                e  = ev && (i == ch);
                mflag[i] = e || (mflag[i] && !(wp && !wdata[6 + i % 2]));
                if (wp) mlvl[i] = wdata[8 + i % 2];
                else if (e && !mmode[i / 2]) mlvl[i] = !mlvl[i];
            end
            if (we) begin
                if (addr < 4) mcmp[addr] = wdata;
                else if (addr < 6) begin
                    int p;
                    p = addr - 4;
                    for (int b = 0; b < 2; b++) begin
                        mstart[2*p+b] = wdata[0 + b];
                        mie[2*p+b]    = wdata[4 + b];
                        moe[2*p+b]    = wdata[10 + b];
                    end
                    mmode[p] = wdata[12];
                end
            end
            cyc++;
        end
    end

    function automatic logic [15:0] mread(input logic [2:0] a);
        logic [15:0] r;
        r = '0;
        if (a < 4) r = mcmp[a];
        else if (a < 6) begin
            int p;
            p = a - 4;
            for (int b = 0; b < 2; b++) begin
                r[0 + b]  = mstart[2*p+b];
                r[4 + b]  = mie[2*p+b];
                r[6 + b]  = mflag[2*p+b];
                r[8 + b]  = mlvl[2*p+b];
                r[10 + b] = moe[2*p+b];
            end
            r[12] = mmode[p];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            logic [3:0] ei, ep, eo;
            for (int i = 0; i < 4; i++) begin
                ei[i] = mflag[i] & mie[i];
                ep[i] = mlvl[i];
                eo[i] = moe[i];
            end
            check("R5 irq", {12'd0, irq}, {12'd0, ei});
            check("R6/R7/R8 pin level", {12'd0, pin}, {12'd0, ep});
            check("R9 pin enable", {12'd0, pin_oe}, {12'd0, eo});
            check("R2 read data", rdata, mread(addr));
        end
    end

    function automatic logic [15:0] ctl(input logic [1:0] st, input logic [1:0] ie,
                                        input logic [1:0] fl, input logic [1:0] lv,
                                        input logic [1:0] oe, input logic md);
        return {3'b000, md, oe, lv, fl, ie, 2'b00, st};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdchk(input logic [2:0] a, input logic [15:0] mask,
                         input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, rdata & mask, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rdchk(3'd4, 16'hFFFF, 16'h0000, "R1 ctl pair0");
        rdchk(3'd5, 16'hFFFF, 16'h0000, "R1 ctl pair1");
        check("R1 pin_oe", {12'd0, pin_oe}, 16'd0);
        check("R1 irq", {12'd0, irq}, 16'd0);
        // R10: reserved bits and unused addresses
        wr(3'd5, 16'hE00C);
        rdchk(3'd5, 16'hFFFF, 16'h0000, "R10 reserved bits");
        rdchk(3'd6, 16'hFFFF, 16'h0000, "R10 unused address");
        // R8/R6/R5: waveform on ch0 starting from loaded level 1; ch1 not started
        wr(3'd0, timer + 16'd6);
        wr(3'd1, timer + 16'd6);
        wr(3'd4, ctl(2'b01, 2'b01, 2'b00, 2'b01, 2'b11, 1'b0));
        check("R8 level loaded", {15'd0, pin[0]}, 16'd1);
        repeat (60) @(negedge clk);
        check("R8 toggled from loaded level", {15'd0, pin[0]}, 16'd0);
        check("R5 irq ch0", {15'd0, irq[0]}, 16'd1);
        rdchk(3'd4, 16'h0040, 16'h0040, "R4 flag set");
        rdchk(3'd4, 16'h0080, 16'h0000, "R3 unstarted channel no event");
        // R4: write 1 keeps, write 0 clears
        wr(3'd4, ctl(2'b01, 2'b01, 2'b11, 2'b00, 2'b11, 1'b0));
        rdchk(3'd4, 16'h00C0, 16'h0040, "R4 write one keeps flag");
        wr(3'd4, ctl(2'b01, 2'b01, 2'b00, 2'b00, 2'b11, 1'b0));
        rdchk(3'd4, 16'h00C0, 16'h0000, "R4 write zero clears");
        check("R5 irq cleared", {15'd0, irq[0]}, 16'd0);
        // R7: direct mode pair1
        wr(3'd2, timer + 16'd6);
        wr(3'd3, timer + 16'd7);
        wr(3'd5, ctl(2'b11, 2'b11, 2'b00, 2'b10, 2'b11, 1'b1));
        repeat (60) @(negedge clk);
        check("R7 direct pins hold", {14'd0, pin[3:2]}, 16'd2);
        rdchk(3'd5, 16'h00C0, 16'h00C0, "R7 events still flagged");
        check("R5 irq pair1", {14'd0, irq[3:2]}, 16'd3);
        check("R9 enables on", {12'd0, pin_oe}, 16'hF);
        wr(3'd5, ctl(2'b11, 2'b11, 2'b11, 2'b10, 2'b00, 1'b1));
        check("R9 enables off", {14'd0, pin_oe[3:2]}, 16'd0);
        // R3: timer value held for three scan rounds gives one event
        tdiv = 12;
        wr(3'd4, ctl(2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0));
        wr(3'd0, timer + 16'd3);
        repeat (80) @(negedge clk);
        check("R3 single toggle on held value", {15'd0, pin[0]}, 16'd1);
        // random traffic, checked by the per-clock reference
        for (int n = 0; n < 3000; n++) begin
            if (n % 50 == 0) tdiv = 4 + ($urandom % 4);
            if ($urandom % 4 == 0) begin
                logic [2:0] a;
                a = 3'($urandom % 6);
                if (a < 4) wr(a, timer + 16'($urandom % 8));
                else wr(a, 16'($urandom));
            end else begin
                addr = 3'($urandom % 8);
                @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule